// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Datapath

This block multiplies two 32-bit operands and either adds the product to a 32-bit accumulator or subtracts it. Four configuration bits pick its arithmetic: signed or unsigned, integer or fixed-point fraction, rounded or truncated fractional products, and whether an overflowing accumulation clamps to a limit. Each multiply-add or multiply-subtract finishes in one clock, and the accumulator is a register. Negative, zero and sticky overflow flags are kept alongside it.

The accumulator can be written directly, and it can be read out through a registered port. In fractional mode with the unsigned bit set, the readout is rounded to a 16-bit value. When an accumulation overflows with clamping enabled, the accumulator is frozen at its limit. It stays frozen until software rewrites the configuration, which clears the overflow flag, or loads the accumulator directly.

Top module: `mac_sat_unit`

## Requirements
- R1: After a synchronous reset, the accumulator, the status word and the read data are all zero, and the read-valid output is low.
- R2: The operation codes are 0 for multiply-add, 1 for multiply-subtract, 2 for load and 3 for read. In signed integer mode, multiply-add and multiply-subtract take the full 32x32 signed product. They add it to the accumulator or subtract it from the accumulator, and the result appears on the next clock.
- R3: In unsigned integer mode (unsigned bit set, fractional bit clear), the operands and the accumulator are treated as unsigned.
- R4: With clamping enabled in signed mode, an accumulation outside the signed 32-bit range sets the accumulator to 0x7FFF_FFFF if the true sum is positive. If the true sum is negative, the accumulator becomes 0x8000_0000.
- R5: With clamping enabled in unsigned integer mode, an overflowing multiply-add sets the accumulator to 0xFFFF_FFFF. An overflowing multiply-subtract sets it to 0x0000_0000.
- R6: While clamping is enabled and the overflow flag is set, multiply-add and multiply-subtract change neither the accumulator nor the flags. A configuration write or a load ends this freeze.
- R7: With clamping disabled, an overflowing accumulation keeps the low 32 bits of the true sum. The overflow flag is sticky: it stays set across later operations that do not overflow.
- R8: In fractional mode, operands are signed Q31 and the product is doubled to align the binary point. When truncating, the product's low 32 bits are dropped, which floors the value.
- R9: In fractional mode with rounding selected, the doubled product rounds to its upper 32 bits. Ties round to even: when the low 32 bits equal 0x8000_0000, the result is rounded up only if its lsb is 1.
- R10: N takes the msb of the new accumulator and Z is set when it is zero. Both are updated only by multiply-add, multiply-subtract and load. Read operations and configuration writes leave them unchanged.
- R11: A read in fractional mode with the unsigned bit set returns the accumulator rounded to 16 bits, with ties going to even. The value sits in the low half of the read data and the upper half is zero. A result that rounds past 0x7FFF stays at 0x7FFF. The accumulator does not change.
- R12: In every other mode, a read returns the full accumulator, one clock later, with read-valid high for that one cycle.
- R13: The configuration input bits are 3 for clamp enable, 2 for unsigned, 1 for fractional and 0 for round. The status word carries those four bits in positions 7 to 4, N in bit 3, Z in bit 2 and V in bit 1. All other bits of the status word read zero. A configuration write also clears V.
- R14: A load writes the accumulator, clears V, and sets N and Z from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write the configuration bits |
| cfg_bits | input | 4 | Clamp, unsigned, fractional and round bits |
| op_valid | input | 1 | Perform op_code this cycle |
| op_code | input | 2 | 0 multiply-add, 1 multiply-subtract, 2 load, 3 read |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| load_data | input | 32 | Value written by a load |
| acc | output | 32 | Accumulator register |
| status | output | 32 | Configuration and flag word |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | Read result valid for one cycle |

## Verification
The properties assume that a configuration write and an operation never share a cycle, because both would update V in that clock. Every driver task in the stimulus issues exactly one of the two and then returns the inputs to idle. The freeze, load and read properties also assume that op_code is stable while op_valid is high. The stimulus meets this by changing inputs only on the falling edge.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MAC  = 2'd0,
    OP_MSAC = 2'd1,
    OP_LOAD = 2'd2,
    OP_READ = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic clamp;
    logic uns;
    logic frac;
    logic rnd;
  } mac_cfg_t;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int W  = 32,
  parameter int PW = 2 * W + 2
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic                 is_uns,
  input  logic                 frac,
  input  logic                 rnd,
  output logic signed [PW-1:0] addend
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] ax, bx, prod, dbl, hi;
  logic [W-1:0] lo;
  logic up;

  always_comb begin
    ax   = is_uns ? {{(W+2){1'b0}}, a} : {{(W+2){a[W-1]}}, a};
    bx   = is_uns ? {{(W+2){1'b0}}, b} : {{(W+2){b[W-1]}}, b};
    prod = ax * bx;
    // fractional: align binary point, then keep the upper word
    dbl  = prod <<< 1;
    lo   = dbl[W-1:0];
    hi   = dbl >>> W;
    up   = rnd && ((lo > HALF) || ((lo == HALF) && hi[0]));
    addend = frac ? (hi + {{(PW-1){1'b0}}, up}) : prod;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W  = 32,
  parameter int PW = 2 * W + 2
) (
  input  logic [W-1:0]         acc,
  input  logic signed [PW-1:0] addend,
  input  logic                 sub,
  input  logic                 is_uns,
  input  logic                 clamp,
  output logic [W-1:0]         nxt,
  output logic                 ovf
);
  logic signed [PW-1:0] ax, sum;
  logic [W-1:0] sat;

  always_comb begin
    ax  = is_uns ? {{(PW-W){1'b0}}, acc} : {{(PW-W){acc[W-1]}}, acc};
    sum = sub ? (ax - addend) : (ax + addend);
    if (is_uns) begin
      ovf = |sum[PW-1:W];
      sat = sub ? '0 : '1;
    end else begin
      ovf = !((&sum[PW-1:W-1]) || !(|sum[PW-1:W-1]));
      sat = sum[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
    nxt = (ovf && clamp) ? sat : sum[W-1:0];
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
  parameter int W  = 32,
  parameter int RW = 16
) (
  input  logic [W-1:0] acc,
  input  logic         round_en,
  output logic [W-1:0] value
);
  localparam int LW = W - RW;
  localparam logic [LW-1:0] HALF = {1'b1, {(LW-1){1'b0}}};
  localparam logic [RW-1:0] PMAX = {1'b0, {(RW-1){1'b1}}};

  logic [RW-1:0] hi, hr;
  logic [LW-1:0] lo;
  logic up;

  always_comb begin
    hi = acc[W-1:LW];
    lo = acc[LW-1:0];
    up = (lo > HALF) || ((lo == HALF) && hi[0]);
    hr = (up && (hi != PMAX)) ? (hi + {{(RW-1){1'b0}}, 1'b1}) : hi;
    value = round_en ? {{LW{1'b0}}, hr} : acc;
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int DATA_W = 32,
  parameter int READ_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_bits,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import mac_pkg::*;
  localparam int PW = 2 * DATA_W + 2;

  mac_cfg_t cfg_q;
  logic [DATA_W-1:0] acc_q, rd_q, acc_nxt, rd_val;
  logic n_q, z_q, v_q, rdv_q, ovf, uns_int;
  logic signed [PW-1:0] addend;
  mac_op_e op;

  assign op      = mac_op_e'(op_code);
  assign uns_int = cfg_q.uns && !cfg_q.frac;

  mac_product #(.W(DATA_W), .PW(PW)) u_prod (
    .a(op_a), .b(op_b), .is_uns(uns_int), .frac(cfg_q.frac),
    .rnd(cfg_q.rnd), .addend(addend)
  );

  mac_accum #(.W(DATA_W), .PW(PW)) u_acc (
    .acc(acc_q), .addend(addend), .sub(op == OP_MSAC), .is_uns(uns_int),
    .clamp(cfg_q.clamp), .nxt(acc_nxt), .ovf(ovf)
  );

  mac_readout #(.W(DATA_W), .RW(READ_W)) u_rd (
    .acc(acc_q), .round_en(cfg_q.frac && cfg_q.uns), .value(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      acc_q <= '0;
      rd_q  <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      if (cfg_wr) begin
        cfg_q <= mac_cfg_t'(cfg_bits);
        v_q   <= 1'b0;
      end
      if (op_valid) begin
        case (op)
          OP_MAC, OP_MSAC: begin
            if (!(cfg_q.clamp && v_q)) begin
              acc_q <= acc_nxt;
              n_q   <= acc_nxt[DATA_W-1];
              z_q   <= (acc_nxt == '0);
              if (ovf) v_q <= 1'b1;
            end
          end
          OP_LOAD: begin
            acc_q <= load_data;
            n_q   <= load_data[DATA_W-1];
            z_q   <= (load_data == '0);
            v_q   <= 1'b0;
          end
          default: begin
            rd_q  <= rd_val;
            rdv_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign acc      = acc_q;
  assign rd_data  = rd_q;
  assign rd_valid = rdv_q;
  assign status   = {{(DATA_W-8){1'b0}}, cfg_q.clamp, cfg_q.uns, cfg_q.frac,
                     cfg_q.rnd, n_q, z_q, v_q, 1'b0};
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [DATA_W-1:0] load_data,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] status,
  input logic              rd_valid
);
  logic frozen;
  assign frozen = status[7] && status[1];

  // R13: unused status bits stay zero
  p_reserved_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (status[DATA_W-1:8] == '0) && !status[0]);

  // R6: frozen accumulator and flags ignore accumulate ops
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_code[1] && frozen && !cfg_wr)
    |=> ($stable(acc) && $stable(status[3:1])));

  // R6, R13: configuration write clears overflow
  p_cfg_clears_v_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !op_valid) |=> !status[1]);

  // R14: load lands in the accumulator and clears V
  p_load_r14: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd2 && !cfg_wr)
    |=> (acc == $past(load_data)) && !status[1]);

  // R11, R10: read leaves accumulator and flags alone and flags valid
  p_read_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd3 && !cfg_wr)
    |=> ($stable(acc) && $stable(status[3:1]) && rd_valid));

  // R4, R5: a new clamped overflow leaves the accumulator at a limit
  p_clamp_limit_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[1]) && status[7])
    |-> (acc == {1'b0, {(DATA_W-1){1'b1}}} || acc == {1'b1, {(DATA_W-1){1'b0}}}
         || acc == '0 || acc == '1));

  // R12: read-valid only follows a read request
  p_rdvalid_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(op_valid && op_code == 2'd3));
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .op_valid(op_valid),
  .op_code(op_code), .load_data(load_data), .acc(acc), .status(status),
  .rd_valid(rd_valid)
);

// File: tb/mac_sat_unit_tb_top.sv
module mac_sat_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_bits = '0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [31:0] op_a = '0, op_b = '0, load_data = '0;
  logic [31:0] acc, status, rd_data;
  logic rd_valid;

  always #5 clk = ~clk;

  mac_sat_unit dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bits(cfg_bits),
    .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b),
    .load_data(load_data), .acc(acc), .status(status), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  typedef struct {
    logic [31:0] acc;
    logic [31:0] st;
    logic [31:0] rd;
    bit          is_rd;
    string       tag;
  } exp_t;
  exp_t exq[$];

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_acc = '0, m_rd = '0;
  bit m_clamp = 0, m_uns = 0, m_frac = 0, m_rnd = 0, m_n = 0, m_z = 0, m_v = 0;

  function automatic logic [31:0] m_status();
    return {24'd0, m_clamp, m_uns, m_frac, m_rnd, m_n, m_z, m_v, 1'b0};
  endfunction

  function automatic void model_acc(bit sub, logic [31:0] a, logic [31:0] b);
    logic signed [127:0] pa, pb, pr, ax, s, addv;
    logic [31:0] lo;
    bit uns, ov;
    if (m_clamp && m_v) return;
    uns = m_uns && !m_frac;
    pa = uns ? $signed({96'd0, a}) : $signed({{96{a[31]}}, a});
    pb = uns ? $signed({96'd0, b}) : $signed({{96{b[31]}}, b});
    pr = pa * pb;
    if (m_frac) begin
      pr = pr * 2;
      lo = pr[31:0];
      addv = pr >>> 32;
      if (m_rnd && (lo > 32'h8000_0000 || (lo == 32'h8000_0000 && addv[0])))
        addv = addv + 1;
    end else addv = pr;
    ax = uns ? $signed({96'd0, m_acc}) : $signed({{96{m_acc[31]}}, m_acc});
    s  = sub ? ax - addv : ax + addv;
    ov = uns ? (s < 0 || s > 128'sd4294967295)
             : (s < -128'sd2147483648 || s > 128'sd2147483647);
    if (ov && m_clamp)
      m_acc = uns ? (sub ? 32'h0 : 32'hFFFF_FFFF)
                  : (s < 0 ? 32'h8000_0000 : 32'h7FFF_FFFF);
    else m_acc = s[31:0];
    m_n = m_acc[31];
    m_z = (m_acc == 0);
    if (ov) m_v = 1;
  endfunction

  task automatic push(bit is_rd, string tag);
    exp_t e;
    e.acc = m_acc; e.st = m_status(); e.rd = m_rd; e.is_rd = is_rd; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic do_cfg(logic [3:0] bits, string tag);
    @(negedge clk);
    cfg_wr = 1; cfg_bits = bits;
    {m_clamp, m_uns, m_frac, m_rnd} = bits;
    m_v = 0;
    push(0, tag);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic do_op(logic [1:0] code, logic [31:0] a, logic [31:0] b,
                       logic [31:0] ld, string tag);
    logic [15:0] hi, lo;
    @(negedge clk);
    op_valid = 1; op_code = code; op_a = a; op_b = b; load_data = ld;
    case (code)
      2'd0: model_acc(0, a, b);
      2'd1: model_acc(1, a, b);
      2'd2: begin m_acc = ld; m_n = ld[31]; m_z = (ld == 0); m_v = 0; end
      default: begin
        if (m_frac && m_uns) begin
          hi = m_acc[31:16]; lo = m_acc[15:0];
          if ((lo > 16'h8000 || (lo == 16'h8000 && hi[0])) && hi != 16'h7FFF) hi = hi + 1;
          m_rd = {16'd0, hi};
        end else m_rd = m_acc;
      end
    endcase
    push(code == 2'd3, tag);
    @(negedge clk);
    op_valid = 0;
  endtask

  // monitor: compare one expected item per clock it was queued for
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exq.size() > 0) begin
        e = exq.pop_front();
        checks++;
        if (acc !== e.acc || status !== e.st ||
            (e.is_rd && (rd_data !== e.rd || rd_valid !== 1'b1))) begin
          fails++;
          $display("FAIL %s: acc=%h st=%h rd=%h rv=%b expected acc=%h st=%h rd=%h",
                   e.tag, acc, status, rd_data, rd_valid, e.acc, e.st, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (acc !== 0 || status !== 0 || rd_data !== 0 || rd_valid !== 0) begin
      fails++;
      $display("FAIL R1 reset: acc=%h st=%h rd=%h rv=%b expected zeros", acc, status, rd_data, rd_valid);
    end
    // signed integer
    do_cfg(4'h0, "R13 cfg signed int");
    do_op(2, 0, 0, 32'd5, "R14 load 5");
    do_op(0, 32'd3, 32'd4, 0, "R2 mac 3*4");
    do_op(1, -32'sd7, 32'd6, 0, "R2 msac -7*6");
    do_op(1, 32'd10, 32'd10, 0, "R2 R10 msac negative");
    do_op(3, 0, 0, 0, "R12 R10 plain read");
    do_op(0, 32'd41, 32'd1, 0, "R10 zero result");
    // wrap without clamp
    do_op(2, 0, 0, 32'h7FFF_FFF0, "R14 load near max");
    do_op(0, 32'h100, 32'h100, 0, "R7 wrap sets V");
    do_op(0, 32'd1, 32'd1, 0, "R7 V sticky");
    do_op(2, 0, 0, 32'd1, "R14 load clears V");
    do_cfg(4'h0, "R10 cfg keeps N Z");
    // signed clamp
    do_cfg(4'h8, "R13 cfg clamp signed");
    do_op(2, 0, 0, 32'h7FFF_FFF0, "R14 load");
    do_op(0, 32'h1_0000, 32'h1_0000, 0, "R4 clamp positive");
    do_op(0, 32'd1, -32'sd5, 0, "R6 frozen mac");
    do_op(1, 32'd9, 32'd9, 0, "R6 frozen msac");
    do_cfg(4'h8, "R6 cfg write clears V");
    do_op(2, 0, 0, 32'h8000_0010, "R14 load negative");
    do_op(0, -32'sh1_0000, 32'h1_0000, 0, "R4 clamp negative");
    do_op(2, 0, 0, 32'h7FFF_FFF0, "R6 load unfreezes");
    do_op(1, -32'sh1_0000, 32'h1_0000, 0, "R4 msac negative product clamps high");
    do_op(2, 0, 0, 32'd3, "R6 load after clamp");
    do_op(0, 32'd2, 32'd2, 0, "R6 accumulates after load");
    // unsigned
    do_cfg(4'hC, "R13 cfg clamp unsigned");
    do_op(2, 0, 0, 32'hFFFF_FFF0, "R14 load");
    do_op(0, 32'h20, 32'd1, 0, "R5 clamp to all ones");
    do_op(2, 0, 0, 32'd5, "R14 load");
    do_op(1, 32'd3, 32'd2, 0, "R5 clamp to zero");
    do_op(2, 0, 0, 32'h8000_0000, "R14 load");
    do_op(0, 32'hFFFF, 32'd2, 0, "R3 unsigned sum");
    do_op(2, 0, 0, 0, "R14 load zero");
    do_op(0, 32'hFFFF_FFFF, 32'd1, 0, "R3 large unsigned operand");
    do_op(3, 0, 0, 0, "R12 unsigned int read full");
    // fractional truncate
    do_cfg(4'h2, "R13 cfg frac trunc");
    do_op(2, 0, 0, 0, "R14 load");
    do_op(0, 32'h4000_0000, 32'h4000_0000, 0, "R8 half times half");
    do_op(0, 32'd1, 32'd1, 0, "R8 tiny product drops");
    do_op(0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, "R8 negative floors");
    do_op(0, 32'h8000_0000, 32'h8000_0000, 0, "R8 R7 minus one squared");
    // fractional round
    do_cfg(4'h3, "R13 cfg frac round");
    do_op(2, 0, 0, 0, "R14 load");
    do_op(0, 32'h8000, 32'h8000, 0, "R9 tie to even stays");
    do_op(0, 32'h1_8000, 32'h8000, 0, "R9 tie odd rounds up");
    do_op(0, 32'h8001, 32'h8000, 0, "R9 above half rounds up");
    do_op(0, 32'h7FFF, 32'h8000, 0, "R9 below half drops");
    do_op(1, 32'h1_8000, 32'h8000, 0, "R9 msac rounded");
    // readout rounding
    do_cfg(4'h6, "R13 cfg frac readout round");
    do_op(2, 0, 0, 32'h1234_8000, "R14 load");
    do_op(3, 0, 0, 0, "R11 tie even");
    do_op(2, 0, 0, 32'h1235_8000, "R14 load");
    do_op(3, 0, 0, 0, "R11 tie odd up");
    do_op(2, 0, 0, 32'h1234_0001, "R14 load");
    do_op(3, 0, 0, 0, "R11 below half");
    do_op(2, 0, 0, 32'h7FFF_C000, "R14 load");
    do_op(3, 0, 0, 0, "R11 clamp at 7FFF");
    do_op(2, 0, 0, 32'hFFFF_8000, "R14 load");
    do_op(3, 0, 0, 0, "R11 negative tie");
    do_cfg(4'h2, "R13 cfg frac no readout round");
    do_op(3, 0, 0, 0, "R12 frac full read");
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule